// File: doc/BRIEF.md
# Quad-Window Byte-Banked Memory with Selectable Decoding

This block is the memory side of a 16-bit processor bus with a 20-bit byte address. Four memory modules occupy fixed 4 KB windows whose bases are 0x34000, 0x36000, 0x3C000 and 0x3F000. Each module holds two byte-wide banks. The even bank carries the low data lane and the odd bank carries the high lane. A bus cycle is described by the address, an active-low high-byte enable, a memory/IO qualifier and active-low read and write strobes. Write data arrives on its own 16-bit port. Read data leaves on another 16-bit port one clock later, with a valid flag.

The build-time parameter `PARTIAL` picks the decoder. With `PARTIAL = 0`, the decoder checks the bits shared by all four windows: A19..A16 must equal 0011 and A14 must be 1. When they match, a one-of-eight decode on {A15,A13,A12} runs, and the modules take outputs 0, 2, 4 and 7. With `PARTIAL = 1`, the shared bits and A12 are ignored and {A15,A13} alone picks the module. Each module then answers at many aliased addresses.

Bank rows are indexed by A[ROW_AW:1]. `ROW_AW = 11` gives the full 2 KB per bank. The default build uses 9, so window address bits above A9 do not reach the storage.

A small state machine records which kind of cycle the previous clock carried. Its states are `S_IDLE` (no memory cycle), `S_READ` (memory read to a module), `S_WRITE` (memory write to a module) and `S_MISS` (memory cycle that matched no module). Every state moves to the state that names the current cycle: the transitions to_read, to_write, to_miss and to_idle can be taken from any state. Read valid is asserted in `S_READ`.

Top module: `qbm_mem_top`

## Requirements
- R1: With `PARTIAL = 0`, during a valid memory cycle `mod_sel` is one-hot. Bit 0 is set in 0x34000–0x34FFF, bit 1 in 0x36000–0x36FFF, bit 2 in 0x3C000–0x3CFFF and bit 3 in 0x3F000–0x3FFFF.
- R2: With `PARTIAL = 0`, an address outside the four windows selects no module. A write there changes no stored byte, and a read there leaves `rvalid` low and `rdata` zero.
- R3: With `PARTIAL = 1`, during a valid memory cycle `mod_sel` has bit {A15,A13} set (a 2-bit index), whatever the other address bits are.
- R4: With `PARTIAL = 1`, a byte written through an aliased address reads back at the module's base address plus the same row offset.
- R5: `mod_sel` is non-zero only when `m_io` is 1 and exactly one of `rd_n` and `wr_n` is 0.
- R6: `addr[0] = 0` enables the even bank on data bits 7..0, and `bhe_n = 0` enables the odd bank on bits 15..8. Both low is a word transfer. With both high, no byte is written and a read returns zero.
- R7: A read to a module raises `rvalid` on the next clock, with the enabled lanes in `rdata` and the disabled lanes zero. When `rvalid` is low, `rdata` is zero.
- R8: A write stores the enabled lanes of `wdata` at the rising clock edge. IO cycles (`m_io = 0`) select no module and change no stored byte.
- R9: During and right after reset, `rvalid` is 0 and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 20 | Byte address |
| bhe_n | input | 1 | Active-low high-byte (odd bank) enable |
| m_io | input | 1 | 1 = memory cycle, 0 = IO cycle |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 16 | Write data, low lane = even bank |
| rdata | output | 16 | Registered read data |
| rvalid | output | 1 | Read data valid (previous cycle was a module read) |
| mod_sel | output | 4 | Combinational one-hot module select |

## Verification
The block's functions meet on one clock in two places. The read return of one cycle lands on the same edge that the next vector's write or lane change is sampled. And in partial mode, an aliased write and a base-address read both reach one row on back-to-back cycles. The bench drives the same vector stream into a full-decode and a partial-decode instance. Aliased writes are followed at once by base reads, miss writes are followed by base reads, and lane patterns are mixed freely. A behavioural byte model for each instance predicts `mod_sel` before every edge and `rvalid`/`rdata` after it, and any difference is a miscompare.

// File: rtl/qbm_pkg.sv
package qbm_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int MODS   = 4;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_MISS
    } cyc_state_t;

    // Output of the one-of-eight decoder that each module takes in full mode.
    function automatic int slot_of(input int m);
        case (m)
            0:       return 0;
            1:       return 2;
            2:       return 4;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/qbm_strobe.sv
module qbm_strobe (
    input  logic m_io,
    input  logic rd_n,
    input  logic wr_n,
    output logic memr,
    output logic memw
);
    always_comb begin
        memr = m_io && !rd_n && wr_n;
        memw = m_io && rd_n && !wr_n;
    end
endmodule

// File: rtl/qbm_addr_dec.sv
module qbm_addr_dec
    import qbm_pkg::*;
#(
    parameter bit PARTIAL = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [MODS-1:0]   hit
);
    generate
        if (PARTIAL) begin : g_partial
            // Only A15 and A13 take part; every other bit is ignored.
            logic [3:0] dec4;
            always_comb dec4 = 4'b0001 << {addr[15], addr[13]};
            for (genvar m = 0; m < MODS; m++) begin : g_map
                assign hit[m] = dec4[m];
            end
        end else begin : g_full
            logic       common_ok;
            logic [7:0] dec8;
            always_comb begin
                common_ok = (addr[19:16] == 4'b0011) && addr[14];
                dec8      = common_ok ? (8'b0000_0001 << {addr[15], addr[13], addr[12]}) : 8'b0;
            end
            for (genvar m = 0; m < MODS; m++) begin : g_map
                assign hit[m] = dec8[slot_of(m)];
            end
        end
    endgenerate
endmodule

// File: rtl/qbm_bank.sv
module qbm_bank
    import qbm_pkg::*;
#(
    parameter int ROW_AW = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_AW-1:0] row,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout
);
    localparam int ROWS = 1 << ROW_AW;

    logic [LANE_W-1:0] store [ROWS];

    always_ff @(posedge clk) begin
        if (we) store[row] <= din;
    end

    assign dout = store[row];
endmodule

// File: rtl/qbm_mem_top.sv
module qbm_mem_top
    import qbm_pkg::*;
#(
    parameter bit PARTIAL = 1'b0,
    parameter int ROW_AW  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [19:0]       addr,
    input  logic              bhe_n,
    input  logic              m_io,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              rvalid,
    output logic [3:0]        mod_sel
);
    logic              memr;
    logic              memw;
    logic [MODS-1:0]   hit;
    logic [LANES-1:0]  lane_en;
    logic [ROW_AW-1:0] row;
    logic [LANE_W-1:0] rd_byte [MODS][LANES];
    logic [DATA_W-1:0] rdata_d;
    cyc_state_t        state_q;
    cyc_state_t        state_d;

    qbm_strobe u_strobe (
        .m_io (m_io),
        .rd_n (rd_n),
        .wr_n (wr_n),
        .memr (memr),
        .memw (memw)
    );

    qbm_addr_dec #(.PARTIAL(PARTIAL)) u_dec (
        .addr (addr),
        .hit  (hit)
    );

    always_comb begin
        mod_sel    = (memr || memw) ? hit : '0;
        lane_en[0] = !addr[0];
        lane_en[1] = !bhe_n;
        row        = addr[ROW_AW:1];
    end

    generate
        for (genvar m = 0; m < MODS; m++) begin : g_mod
            for (genvar b = 0; b < LANES; b++) begin : g_lane
                qbm_bank #(.ROW_AW(ROW_AW)) u_bank (
                    .clk  (clk),
                    .we   (memw && mod_sel[m] && lane_en[b]),
                    .row  (row),
                    .din  (wdata[b*LANE_W +: LANE_W]),
                    .dout (rd_byte[m][b])
                );
            end
        end
    endgenerate

    // Read return: gather the enabled lanes of the selected module.
    always_comb begin
        rdata_d = '0;
        for (int m = 0; m < MODS; m++) begin
            for (int b = 0; b < LANES; b++) begin
                if (memr && mod_sel[m] && lane_en[b])
                    rdata_d[b*LANE_W +: LANE_W] = rd_byte[m][b];
            end
        end
    end

    // Cycle-kind state machine: next state names the current bus cycle.
    always_comb begin
        if (memr && |hit)                  state_d = S_READ;   // to_read
        else if (memw && |hit)             state_d = S_WRITE;  // to_write
        else if (memr || memw)             state_d = S_MISS;   // to_miss
        else                               state_d = S_IDLE;   // to_idle
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rdata   <= '0;
        end else begin
            state_q <= state_d;
            rdata   <= rdata_d;
        end
    end

    always_comb begin
        unique case (state_q)
            S_IDLE:  rvalid = 1'b0;
            S_READ:  rvalid = 1'b1;
            S_WRITE: rvalid = 1'b0;
            S_MISS:  rvalid = 1'b0;
            default: rvalid = 1'b0;
        endcase
    end

    // ---------------- assertions ----------------
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mod_sel));

    p_sel_needs_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_sel != 4'b0) |-> (m_io && (rd_n != wr_n)));

    p_io_untouched_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !m_io |-> (mod_sel == 4'b0));

    p_rvalid_follows_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_io && !rd_n && wr_n && (mod_sel != 4'b0)) |=> rvalid);

    p_quiet_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == 16'h0000));

    p_odd_lane_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_io && !rd_n && wr_n && bhe_n) |=> (rdata[15:8] == 8'h00));

    generate
        if (!PARTIAL) begin : g_full_chk
            p_full_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (mod_sel != 4'b0) |-> ((addr[19:16] == 4'b0011) && addr[14]));
        end else begin : g_part_chk
            p_alias_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (mod_sel != 4'b0) |-> mod_sel[{addr[15], addr[13]}]);
        end
    endgenerate
endmodule

// File: tb/qbm_mem_top_tb.sv
module qbm_mem_top_tb;
    localparam int ROW_AW = 9;
    localparam int ROWS   = 1 << ROW_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        bhe_n = 1'b1;
    logic        m_io = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata_f, rdata_p;
    logic        rvalid_f, rvalid_p;
    logic [3:0]  sel_f, sel_p;

    int vectors = 0;
    int fails   = 0;

    logic [7:0] mf [4][2][ROWS];
    logic [7:0] mp [4][2][ROWS];
    logic [15:0] exp_rd_f, exp_rd_p;
    logic        exp_rv_f, exp_rv_p;

    always #2 clk = ~clk;

    qbm_mem_top #(.PARTIAL(1'b0), .ROW_AW(ROW_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .bhe_n(bhe_n), .m_io(m_io),
        .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
        .rdata(rdata_f), .rvalid(rvalid_f), .mod_sel(sel_f)
    );

    qbm_mem_top #(.PARTIAL(1'b1), .ROW_AW(ROW_AW)) u_dut_alias (
        .clk(clk), .rst_n(rst_n), .addr(addr), .bhe_n(bhe_n), .m_io(m_io),
        .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
        .rdata(rdata_p), .rvalid(rvalid_p), .mod_sel(sel_p)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h addr=%h", req, what, act, exp, addr);
        end
    endtask

    function automatic bit cyc_ok(input logic mio, input logic r, input logic w);
        return mio && (r != w);
    endfunction

    function automatic logic [3:0] ref_full(input logic [19:0] a);
        if (a >= 20'h34000 && a < 20'h35000) return 4'b0001;
        if (a >= 20'h36000 && a < 20'h37000) return 4'b0010;
        if (a >= 20'h3C000 && a < 20'h3D000) return 4'b0100;
        if (a >= 20'h3F000 && a <= 20'h3FFFF) return 4'b1000;
        return 4'b0000;
    endfunction

    function automatic logic [3:0] ref_part(input logic [19:0] a);
        return 4'b0001 << {a[15], a[13]};
    endfunction

    function automatic int idx_of(input logic [3:0] s);
        for (int i = 0; i < 4; i++) if (s[i]) return i;
        return -1;
    endfunction

    // One bus vector: entered and left at a falling edge.
    task automatic apply(input string req, input logic [19:0] a, input logic bh,
                         input logic mio, input logic r, input logic w, input logic [15:0] wd);
        logic [3:0] sf, sp;
        int         row, kf, kp;
        addr = a; bhe_n = bh; m_io = mio; rd_n = r; wr_n = w; wdata = wd;
        #1;
        sf = cyc_ok(mio, r, w) ? ref_full(a) : 4'b0;
        sp = cyc_ok(mio, r, w) ? ref_part(a) : 4'b0;
        chk(req, "mod_sel full", {28'b0, sel_f}, {28'b0, sf});
        chk(req, "mod_sel partial", {28'b0, sel_p}, {28'b0, sp});
        @(posedge clk);
        row = int'(a[ROW_AW:1]);
        kf = idx_of(sf);
        kp = idx_of(sp);
        exp_rv_f = 1'b0; exp_rd_f = '0;
        exp_rv_p = 1'b0; exp_rd_p = '0;
        if (kf >= 0 && !r) begin
            exp_rv_f = 1'b1;
            if (!a[0]) exp_rd_f[7:0]  = mf[kf][0][row];
            if (!bh)   exp_rd_f[15:8] = mf[kf][1][row];
        end
        if (kp >= 0 && !r) begin
            exp_rv_p = 1'b1;
            if (!a[0]) exp_rd_p[7:0]  = mp[kp][0][row];
            if (!bh)   exp_rd_p[15:8] = mp[kp][1][row];
        end
        if (kf >= 0 && !w) begin
            if (!a[0]) mf[kf][0][row] = wd[7:0];
            if (!bh)   mf[kf][1][row] = wd[15:8];
        end
        if (kp >= 0 && !w) begin
            if (!a[0]) mp[kp][0][row] = wd[7:0];
            if (!bh)   mp[kp][1][row] = wd[15:8];
        end
        @(negedge clk);
        chk(req, "rvalid full", {31'b0, rvalid_f}, {31'b0, exp_rv_f});
        chk(req, "rdata full", {16'b0, rdata_f}, {16'b0, exp_rd_f});
        chk(req, "rvalid partial", {31'b0, rvalid_p}, {31'b0, exp_rv_p});
        chk(req, "rdata partial", {16'b0, rdata_p}, {16'b0, exp_rd_p});
    endtask

    task automatic wr_word(input string req, input logic [19:0] a, input logic [15:0] d);
        apply(req, a, 1'b0, 1'b1, 1'b1, 1'b0, d);
    endtask

    task automatic rd_word(input string req, input logic [19:0] a);
        apply(req, a, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [19:0] bases [4];
        bases[0] = 20'h34000; bases[1] = 20'h36000; bases[2] = 20'h3C000; bases[3] = 20'h3F000;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9", "rvalid full in reset", {31'b0, rvalid_f}, 32'd0);
        chk("R9", "rdata full in reset", {16'b0, rdata_f}, 32'd0);
        chk("R9", "rvalid partial in reset", {31'b0, rvalid_p}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "rdata partial after reset", {16'b0, rdata_p}, 32'd0);

        // Clear every row of every module (R8)
        for (int m = 0; m < 4; m++)
            for (int r = 0; r < ROWS; r++)
                wr_word("R8", bases[m] + 20'(r * 2), 16'h0000);

        // R1/R7: word write and readback at each base and near the window top
        for (int m = 0; m < 4; m++) begin
            wr_word("R1", bases[m] + 20'h002, 16'hA100 + 16'(m));
            rd_word("R7", bases[m] + 20'h002);
            wr_word("R1", bases[m] + 20'hFFE, 16'h5E00 + 16'(m));
            rd_word("R1", bases[m] + 20'hFFE);
        end

        // R6: byte lanes
        apply("R6", 20'h36010, 1'b1, 1'b1, 1'b1, 1'b0, 16'hDEAD);
        apply("R6", 20'h36011, 1'b0, 1'b1, 1'b1, 1'b0, 16'hBEEF);
        rd_word("R6", 20'h36010);
        apply("R6", 20'h36011, 1'b1, 1'b1, 1'b1, 1'b0, 16'h7777);
        apply("R6", 20'h36011, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0000);
        rd_word("R6", 20'h36010);
        apply("R6", 20'h3C011, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000);

        // R2/R4: miss in full mode that aliases in partial mode, then base read
        wr_word("R2", 20'h35004, 16'hC3C3);
        rd_word("R4", 20'h34004);
        wr_word("R4", 20'hA6008, 16'h1234);
        rd_word("R4", 20'h36008);
        wr_word("R4", 20'hFF00A, 16'h9876);
        rd_word("R4", 20'h3F00A);
        rd_word("R2", 20'h00000);
        rd_word("R3", 20'h8A00A);

        // R5/R8: IO cycles and both strobes low
        apply("R8", 20'h34002, 1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFF);
        apply("R8", 20'h34002, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000);
        apply("R5", 20'h34002, 1'b0, 1'b1, 1'b0, 1'b0, 16'hEEEE);
        apply("R5", 20'h34002, 1'b0, 1'b1, 1'b1, 1'b1, 16'hEEEE);
        rd_word("R8", 20'h34002);

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [19:0] a;
            logic [31:0] rv;
            logic        r, w;
            rv = $urandom;
            case (rv[1:0])
                2'd0, 2'd1: a = bases[rv[3:2]] + 20'($urandom % 4096);
                default:    a = 20'($urandom);
            endcase
            r = rv[4];
            w = rv[5] ? !r : rv[6];
            apply(rv[7] ? "R3" : "R1", a, rv[8], (rv[10:9] != 2'b00), r, w, 16'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule